// File: doc/BRIEF.md
# Non-blocking Aggregation Cache

This block keeps running per-key aggregates on chip for a packet stream and accepts one lookup per clock. Each request brings a key and an operand. The key's low bits pick a set of eight ways. If the full key matches a valid way, that entry's packet count rises by one and the operand is added to its running sum. If no way matches, the key is installed at once as a fresh entry that starts from a fixed initial sum, and the same fold is applied to it. The block never fetches anything from slower memory, so every request costs the same single cycle.

When an install lands in a set whose eight ways are all valid, the least recently used way is replaced. Its key, sum and packet count leave the block as an eviction record on a valid/ready stream, so that a downstream agent can merge the partial aggregate into a larger store. A small FIFO holds these records. Only a full FIFO can stall the input. Two free-running counters report the number of accepted lookups and the number of evictions, and together they give the eviction ratio.

Top module: `agg_cache`

## Requirements
- R1: When `in_ready` is high, a request with `in_valid` high is accepted on that clock edge. The block can accept one request on every cycle, with no idle cycles between them.
- R2: On a hit, the matching entry's count rises by 1 and its sum rises by the zero-extended operand. The result is visible in the entry's eventual eviction record.
- R3: On a miss, the key is installed with count 1 and sum `INIT_SUM` + operand. Any earlier aggregate for that key plays no part.
- R4: The set index is `in_key[IDX_W-1:0]`, where `IDX_W` = log2(`SETS`). A hit requires the full key to match. Traffic to one set never evicts or changes entries of another set.
- R5: Each set holds `WAYS` (8) entries. A miss uses a free way while one exists, and it produces no eviction in that case. A miss in a full set replaces that set's least recently used entry.
- R6: A hit or an install makes the entry the most recently used one in its set.
- R7: An eviction record carries the displaced entry's key, sum and count in `ev_key`, `ev_sum` and `ev_cnt`. Records leave in the order in which the evictions happened.
- R8: `ev_valid` is high while at least one record is queued. While `ev_valid` is high and `ev_ready` is low, the record on the output does not change.
- R9: `in_ready` is low exactly when `EV_DEPTH` records are queued. A request presented while `in_ready` is low is ignored: it changes no entry and no counter.
- R10: `lookup_count` rises by 1 for each accepted request. `evict_count` rises by 1 for each eviction record produced.
- R11: After reset all ways are empty, both counters read 0, `ev_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_key | input | 16 | Aggregation key |
| in_opnd | input | 16 | Operand added to the sum |
| ev_valid | output | 1 | Eviction record available |
| ev_ready | input | 1 | Consumer takes the record |
| ev_key | output | 16 | Key of the evicted entry |
| ev_sum | output | 32 | Sum of the evicted entry |
| ev_cnt | output | 16 | Packet count of the evicted entry |
| lookup_count | output | 32 | Accepted requests since reset |
| evict_count | output | 32 | Evictions since reset |

## Verification
On every cycle the assertions check the stream-side rules. A record held under backpressure must stay stable. The lookup counter may move only on an accepted request. Evictions in flight must never exceed the FIFO depth. A newly counted eviction must show up as a valid record, and a pop must always free room for input. Which key a full set gives up, whether a hit has refreshed its recency, whether sets stay apart, and what the fold arithmetic yields can only be seen in the bench's scenarios. There, a recency-ordered reference model predicts every record and every counter value, and each of these is compared against the design.

// File: rtl/agg_pkg.sv
package agg_pkg;

    localparam int KEY_W  = 16;
    localparam int OPND_W = 16;
    localparam int SUM_W  = 32;
    localparam int CNT_W  = 16;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [SUM_W-1:0]  sum_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // one way of the cache
    typedef struct packed {
        logic valid;
        key_t key;
        sum_t sum;
        cnt_t cnt;
    } entry_t;

    // record leaving on the eviction stream
    typedef struct packed {
        key_t key;
        sum_t sum;
        cnt_t cnt;
    } evrec_t;

    function automatic sum_t fold_sum(sum_t acc, opnd_t x);
        return acc + sum_t'(x);
    endfunction

    function automatic cnt_t fold_cnt(cnt_t c);
        return c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/agg_victim_sel.sv
module agg_victim_sel #(
    parameter int WAYS  = 8,
    parameter int AGE_W = 3,
    parameter int WAY_W = 3
) (
    input  logic [WAYS-1:0]            valid_vec,
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    output logic [WAY_W-1:0]           way,
    output logic                       occupied
);
    logic free_found;

    always_comb begin
        free_found = 1'b0;
        way        = '0;
        // the lowest-numbered free way wins
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                way        = WAY_W'(w);
                free_found = 1'b1;
            end
        end
        // all ways in use: take the oldest one
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ages[w] == AGE_W'(WAYS - 1)) begin
                    way = WAY_W'(w);
                end
            end
        end
        occupied = !free_found;
    end

endmodule

// File: rtl/agg_evict_fifo.sv
module agg_evict_fifo
    import agg_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  evrec_t push_rec,
    input  logic   pop,
    output logic   full,
    output logic   out_valid,
    output evrec_t head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    evrec_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [OCC_W-1:0] occ;

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_rec;
                wr_ptr      <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
        end
    end

    assign full      = (occ == OCC_W'(DEPTH));
    assign out_valid = (occ != '0);
    assign head      = mem[rd_ptr];

endmodule

// File: rtl/agg_cache.sv
module agg_cache
    import agg_pkg::*;
#(
    parameter int   SETS     = 4,
    parameter int   WAYS     = 8,
    parameter int   EV_DEPTH = 4,
    parameter int   STAT_W   = 32,
    parameter sum_t INIT_SUM = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [OPND_W-1:0] in_opnd,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [KEY_W-1:0]  ev_key,
    output logic [SUM_W-1:0]  ev_sum,
    output logic [CNT_W-1:0]  ev_cnt,
    output logic [STAT_W-1:0] lookup_count,
    output logic [STAT_W-1:0] evict_count
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;

    // storage and recency state
    entry_t                     ent_q [SETS][WAYS];
    logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];

    logic [IDX_W-1:0]           idx;
    logic [WAYS-1:0]            hit_vec;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][AGE_W-1:0] set_ages;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           vic_way;
    logic                       vic_occupied;
    logic [WAY_W-1:0]           tgt_way;
    logic [AGE_W-1:0]           tgt_age;
    logic                       fire;
    logic                       evict;
    logic                       fifo_full;
    logic                       pop;
    entry_t                     cur_ent;
    entry_t                     new_ent;
    evrec_t                     vic_rec;
    evrec_t                     head_rec;

    assign idx      = in_key[IDX_W-1:0];
    assign set_ages = age_q[idx];

    // per-way tag compare
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign set_valid[g] = ent_q[idx][g].valid;
        assign hit_vec[g]   = ent_q[idx][g].valid && (ent_q[idx][g].key == in_key);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    agg_victim_sel #(
        .WAYS (WAYS),
        .AGE_W(AGE_W),
        .WAY_W(WAY_W)
    ) u_vsel (
        .valid_vec(set_valid),
        .ages     (set_ages),
        .way      (vic_way),
        .occupied (vic_occupied)
    );

    assign tgt_way = hit ? hit_way : vic_way;
    assign tgt_age = set_ages[tgt_way];
    assign fire    = in_valid && in_ready;
    assign evict   = fire && !hit && vic_occupied;

    // fold on hit, fresh install on miss
    always_comb begin
        cur_ent       = ent_q[idx][tgt_way];
        new_ent.valid = 1'b1;
        if (hit) begin
            new_ent.key = cur_ent.key;
            new_ent.sum = fold_sum(cur_ent.sum, in_opnd);
            new_ent.cnt = fold_cnt(cur_ent.cnt);
        end else begin
            new_ent.key = in_key;
            new_ent.sum = fold_sum(INIT_SUM, in_opnd);
            new_ent.cnt = fold_cnt('0);
        end
        vic_rec.key = cur_ent.key;
        vic_rec.sum = cur_ent.sum;
        vic_rec.cnt = cur_ent.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ent_q[s][w]    <= '0;
                    age_q[s][w]    <= AGE_W'(w);
                end
            end
            lookup_count <= '0;
            evict_count  <= '0;
        end else if (fire) begin
            ent_q[idx][tgt_way] <= new_ent;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tgt_way) begin
                    age_q[idx][w] <= '0;
                end else if (set_ages[w] < tgt_age) begin
                    age_q[idx][w] <= set_ages[w] + AGE_W'(1);
                end
            end
            lookup_count <= lookup_count + STAT_W'(1);
            if (evict) begin
                evict_count <= evict_count + STAT_W'(1);
            end
        end
    end

    assign pop = ev_valid && ev_ready;

    agg_evict_fifo #(
        .DEPTH(EV_DEPTH)
    ) u_evq (
        .clk      (clk),
        .rst      (rst),
        .push     (evict),
        .push_rec (vic_rec),
        .pop      (pop),
        .full     (fifo_full),
        .out_valid(ev_valid),
        .head     (head_rec)
    );

    assign in_ready = !fifo_full;
    assign ev_key   = head_rec.key;
    assign ev_sum   = head_rec.sum;
    assign ev_cnt   = head_rec.cnt;

endmodule

// File: rtl/agg_cache_chk.sv
module agg_cache_chk
    import agg_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int EV_DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [KEY_W-1:0]  ev_key,
    input logic [SUM_W-1:0]  ev_sum,
    input logic [CNT_W-1:0]  ev_cnt,
    input logic [STAT_W-1:0] lookup_count,
    input logic [STAT_W-1:0] evict_count
);
    logic [STAT_W-1:0] pops_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pops_q <= '0;
        end else if (ev_valid && ev_ready) begin
            pops_q <= pops_q + STAT_W'(1);
        end
    end

    AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_key) && $stable(ev_sum) && $stable(ev_cnt)); // R8

    AST_LOOKUP_STEP: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> lookup_count == $past(lookup_count) + STAT_W'(1)); // R10

    AST_IGNORED_REQ: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(lookup_count)); // R9

    AST_EV_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        (evict_count - pops_q) <= STAT_W'(EV_DEPTH)); // R9

    AST_EV_SHOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (evict_count != $past(evict_count)) |-> ev_valid); // R7

    AST_POP_FREES: assert property (@(posedge clk) disable iff (rst)
        ev_valid && ev_ready |=> in_ready); // R9

endmodule

bind agg_cache agg_cache_chk #(
    .STAT_W  (STAT_W),
    .EV_DEPTH(EV_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .ev_key      (ev_key),
    .ev_sum      (ev_sum),
    .ev_cnt      (ev_cnt),
    .lookup_count(lookup_count),
    .evict_count (evict_count)
);

// File: tb/agg_cache_bench.sv
module agg_cache_bench;
    import agg_pkg::*;

    localparam int SETS     = 4;
    localparam int WAYS     = 8;
    localparam int EV_DEPTH = 4;
    localparam int STAT_W   = 32;
    localparam logic [31:0] INIT = 32'd0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [KEY_W-1:0]  in_key = '0;
    logic [OPND_W-1:0] in_opnd = '0;
    logic              ev_valid;
    logic              ev_ready = 1'b0;
    logic [KEY_W-1:0]  ev_key;
    logic [SUM_W-1:0]  ev_sum;
    logic [CNT_W-1:0]  ev_cnt;
    logic [STAT_W-1:0] lookup_count;
    logic [STAT_W-1:0] evict_count;

    always #10 clk = ~clk;

    agg_cache #(
        .SETS    (SETS),
        .WAYS    (WAYS),
        .EV_DEPTH(EV_DEPTH),
        .STAT_W  (STAT_W),
        .INIT_SUM(INIT)
    ) u_agg_cache (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_key      (in_key),
        .in_opnd     (in_opnd),
        .ev_valid    (ev_valid),
        .ev_ready    (ev_ready),
        .ev_key      (ev_key),
        .ev_sum      (ev_sum),
        .ev_cnt      (ev_cnt),
        .lookup_count(lookup_count),
        .evict_count (evict_count)
    );

    // reference model: one recency-ordered list, most recent first
    typedef struct {
        int unsigned key;
        logic [31:0] sum;
        int unsigned cnt;
    } rec_t;

    rec_t        mru[$];
    rec_t        exp_ev[$];
    int unsigned exp_lookups = 0;
    int unsigned exp_evicts  = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_req = "R11";
    bit          done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (scenario %s) %s: actual %0d expected %0d",
                     req, cur_req, what, act, exp);
        end
    endtask

    task automatic model_apply(input int unsigned key, input int unsigned opnd);
        int   s;
        int   pos;
        int   in_set;
        int   last;
        rec_t r;
        s   = int'(key % SETS);
        pos = -1;
        for (int i = 0; i < mru.size(); i++) begin
            if (mru[i].key == key) pos = i;
        end
        if (pos >= 0) begin
            r = mru[pos];
            mru.delete(pos);
            r.sum = r.sum + opnd;
            r.cnt = r.cnt + 1;
            mru.push_front(r);
        end else begin
            in_set = 0;
            last   = -1;
            for (int i = 0; i < mru.size(); i++) begin
                if (int'(mru[i].key % SETS) == s) begin
                    in_set++;
                    last = i;
                end
            end
            if (in_set == WAYS) begin
                exp_ev.push_back(mru[last]);
                mru.delete(last);
                exp_evicts++;
            end
            r.key = key;
            r.sum = INIT + opnd;
            r.cnt = 1;
            mru.push_front(r);
        end
        exp_lookups++;
    endtask

    // compare, then drive the next cycle's inputs and advance the model
    task automatic step(input bit v, input int unsigned key,
                        input int unsigned opnd, input bit evr);
        bit exp_ready;
        bit fire;
        bit pop;
        @(negedge clk);
        exp_ready = (exp_ev.size() < EV_DEPTH);
        chk(in_ready == exp_ready, "R9", "in_ready", longint'(in_ready), longint'(exp_ready));
        chk(ev_valid == (exp_ev.size() > 0), "R8", "ev_valid",
            longint'(ev_valid), longint'(exp_ev.size() > 0));
        if (ev_valid && exp_ev.size() > 0) begin
            chk(ev_key == KEY_W'(exp_ev[0].key), "R7", "ev_key",
                longint'(ev_key), longint'(exp_ev[0].key));
            chk(ev_sum == exp_ev[0].sum, "R7", "ev_sum",
                longint'(ev_sum), longint'(exp_ev[0].sum));
            chk(ev_cnt == CNT_W'(exp_ev[0].cnt), "R7", "ev_cnt",
                longint'(ev_cnt), longint'(exp_ev[0].cnt));
        end
        chk(lookup_count == exp_lookups, "R10", "lookup_count",
            longint'(lookup_count), longint'(exp_lookups));
        chk(evict_count == exp_evicts, "R10", "evict_count",
            longint'(evict_count), longint'(exp_evicts));
        in_valid = v;
        in_key   = KEY_W'(key);
        in_opnd  = OPND_W'(opnd);
        ev_ready = evr;
        fire = v && exp_ready;
        pop  = evr && (exp_ev.size() > 0);
        if (pop) void'(exp_ev.pop_front());
        if (fire) model_apply(key & 32'hFFFF, opnd & 32'hFFFF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: state right after reset
        cur_req = "R11";
        step(0, 0, 0, 1);
        chk(in_ready == 1'b1 && ev_valid == 1'b0 && lookup_count == 0 && evict_count == 0,
            "R11", "reset outputs", longint'(lookup_count), 0);

        // R2: repeated hits on one key accumulate count and sum
        cur_req = "R2";
        for (int i = 0; i < 6; i++) step(1, 32'h40, i + 3, 1);

        // R3: fresh installs fill the rest of set 0, no evictions yet
        cur_req = "R3";
        for (int k = 2; k <= 8; k++) step(1, k * 32'h40, k * 7, 1);

        // R5: ninth key in a full set pushes out the oldest (0x40, count 6)
        cur_req = "R5";
        step(1, 9 * 32'h40, 1, 1);
        step(0, 0, 0, 1);

        // R6: a hit refreshes 0x80, so the next miss displaces 0xC0 instead
        cur_req = "R6";
        step(1, 32'h80, 100, 1);
        step(1, 10 * 32'h40, 5, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);

        // R4: same low bits share a set, full key is the tag, sets stay apart
        cur_req = "R4";
        for (int k = 0; k < 8; k++) step(1, 1 + 4 * k, k, 1);
        step(1, 32'h0101, 9, 1);
        for (int k = 0; k < 12; k++) step(1, 2 + 4 * k, k, 1);
        step(1, 1 + 4 * 9, 2, 1);
        step(0, 0, 0, 1);

        // R8: hold records under backpressure while evictions pile up
        cur_req = "R8";
        for (int k = 0; k < 14; k++) step(1, 3 + 4 * k, k + 1, 0);

        // R9: input stalled with a full queue; offered requests must be ignored
        cur_req = "R9";
        for (int k = 14; k < 22; k++) step(1, 3 + 4 * k, k + 1, 0);
        for (int k = 0; k < 8; k++) step(0, 0, 0, 1);

        // R1: back-to-back traffic with the consumer always ready
        cur_req = "R1";
        for (int k = 0; k < 500; k++) step(1, $urandom % 256, $urandom % 65536, 1);

        // R7: mixed traffic with random consumer stalls, checks record order
        cur_req = "R7";
        for (int k = 0; k < 3000; k++)
            step(($urandom % 8) != 0, $urandom % 64, $urandom % 65536, ($urandom % 10) < 7);

        // R10: drain and final counter comparison
        cur_req = "R10";
        for (int k = 0; k < 10; k++) step(0, 0, 0, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule